// File: doc/BRIEF.md
# Delta Sample Memory Reader

This block feeds a 1-bit delta-coded sample stream from a 16-bit CPU address space into a one-byte sample buffer. Software programs a start selector, a length selector and a flags byte through a small register write port, then switches the channel on. From that point the block asks the bus for a byte whenever its buffer is empty and bytes remain. It places each returned byte in the buffer, where the downstream output unit picks it up with a consume pulse.

The block keeps a current-address counter and a bytes-remaining counter. The address counter stays inside the upper half of the address space. When the remaining count reaches zero, the block either restarts the sample from its programmed start or stops. When it stops and interrupts are enabled, it raises a sticky interrupt flag. A combinational status byte reports whether a sample is in progress and whether the interrupt flag is set.

Top module: `dsm_reader`

## Requirements
- R1: After reset, fetch_req, irq and buf_full are 0 and status reads 0.
- R2: A control write (wr_sel = 3) with wr_data bit 4 set, made while bytes remaining is zero, loads the current address with 0xC000 + 64*S and the remaining count with 16*L + 1. S is the start selector (wr_sel = 1) and L is the length selector (wr_sel = 2). From the next cycle, fetch_req is 1 and fetch_addr shows that start.
- R3: fetch_req is 1 exactly when the buffer is empty and bytes remaining is nonzero.
- R4: A fetch_ack while fetch_req is 1 stores fetch_data into the buffer at that edge. At the same edge the address advances by one and bytes remaining drops by one.
- R5: An address advance from 0xFFFF gives 0x8000.
- R6: When the last byte is acknowledged and the loop flag is set, the address and remaining count reload from the current selectors, and the interrupt flag is not raised. The loop flag is bit 6 of a flags write (wr_sel = 0).
- R7: When the last byte is acknowledged, the loop flag is clear and interrupt enable is set, irq rises at that edge. It then stays high until it is cleared. Interrupt enable is bit 7 of a flags write.
- R8: A flags write with bit 7 clear clears irq, and a flags write with bit 7 set leaves irq unchanged. Any control write clears irq.
- R9: A control write with bit 4 clear forces bytes remaining to zero, and fetch_req drops. A control write with bit 4 set while bytes remain does not restart the sample: the address carries on.
- R10: buf_take empties a full buffer at the next edge; buf_take on an empty buffer and fetch_ack while fetch_req is 0 have no effect.
- R11: status bit 4 is 1 while bytes remain, status bit 7 equals irq, and all other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 flags, 1 start, 2 length, 3 control |
| wr_data | input | REG_W | Register write data |
| status | output | REG_W | Status byte: bit 4 active, bit 7 interrupt |
| fetch_req | output | 1 | Byte fetch request |
| fetch_addr | output | ADDR_W | Address of the byte to fetch |
| fetch_ack | input | 1 | Fetch complete, fetch_data valid |
| fetch_data | input | DATA_W | Returned sample byte |
| buf_full | output | 1 | Sample buffer holds a byte |
| buf_data | output | DATA_W | Buffered sample byte |
| buf_take | input | 1 | Output unit consumes the buffered byte |
| irq | output | 1 | Interrupt request, level |

## Verification
Every register write, acknowledge and consume acts at the rising edge where it is sampled. Status, fetch_req, fetch_addr, buf_full and irq therefore show the result one edge after the stimulus is applied, and no result depends on an input combinationally. The bench drives inputs just after a rising edge. It advances a behavioural model at each rising edge and compares every output at the following falling edge, so each comparison lands in the cycle its result is due. Directed checks such as the wrap point, the loop reload and the interrupt clear wait on the model's acknowledge count and then sample at the falling edge right after that edge.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

   typedef enum logic [1:0] {
      SEL_FLAGS  = 2'd0,
      SEL_START  = 2'd1,
      SEL_LENGTH = 2'd2,
      SEL_CTRL   = 2'd3
   } dsm_sel_e;

   localparam int unsigned FLG_IRQ_EN  = 7;
   localparam int unsigned FLG_LOOP    = 6;
   localparam int unsigned CTRL_ENABLE = 4;
   localparam int unsigned STS_ACTIVE  = 4;
   localparam int unsigned STS_IRQ     = 7;

endpackage

// File: rtl/dsm_addr_ctr.sv
module dsm_addr_ctr #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned REG_W      = 8,
   parameter int unsigned ADDR_SHIFT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [REG_W-1:0]  base_sel,
   output logic [ADDR_W-1:0] addr
);
   localparam int HI_W = int'(ADDR_W) - int'(REG_W) - int'(ADDR_SHIFT);
   localparam logic [ADDR_W-1:0] HI_MASK   = ~({ADDR_W{1'b1}} >> HI_W);
   localparam logic [ADDR_W-1:0] TOP_ADDR  = '1;
   localparam logic [ADDR_W-1:0] WRAP_ADDR = {1'b1, {(ADDR_W-1){1'b0}}};

   generate
      if (HI_W < 1) begin : g_bad_geom
         $error("dsm_addr_ctr: ADDR_W must exceed REG_W + ADDR_SHIFT");
      end
   endgenerate

   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] addr_q;

   assign base = HI_MASK | (ADDR_W'(base_sel) << ADDR_SHIFT);
   assign addr = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (load) begin
         addr_q <= base;
      end else if (step) begin
         addr_q <= (addr_q == TOP_ADDR) ? WRAP_ADDR : addr_q + 1'b1;
      end
   end

   a_r2_load_base: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> addr_q == $past(base))
      else $error("start address not loaded");

   a_r4_step_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && addr_q != TOP_ADDR) |=> addr_q == $past(addr_q) + 1'b1)
      else $error("address did not advance");

   a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && addr_q == TOP_ADDR) |=> addr_q == WRAP_ADDR)
      else $error("address wrap wrong");

endmodule

// File: rtl/dsm_remain_ctr.sv
module dsm_remain_ctr #(
   parameter int unsigned REG_W     = 8,
   parameter int unsigned LEN_SHIFT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             kill,
   input  logic             reload,
   input  logic             step,
   input  logic [REG_W-1:0] len_sel,
   output logic             active,
   output logic             last
);
   localparam int unsigned CNT_W = REG_W + LEN_SHIFT;

   generate
      if (LEN_SHIFT < 1) begin : g_bad_shift
         $error("dsm_remain_ctr: LEN_SHIFT must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] len_full;
   logic [CNT_W-1:0] cnt_q;

   assign len_full = (CNT_W'(len_sel) << LEN_SHIFT) | CNT_W'(1);
   assign active   = (cnt_q != '0);
   assign last     = (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (kill) begin
         cnt_q <= '0;
      end else if (reload) begin
         cnt_q <= len_full;
      end else if (step && active) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   a_r9_kill_zero: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> !active)
      else $error("disable did not clear remaining count");

   a_r2_reload_len: assert property (@(posedge clk) disable iff (!rst_n)
      (reload && !kill) |=> cnt_q == $past(len_full))
      else $error("length not loaded");

   a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (step && active && !kill && !reload) |=> cnt_q == $past(cnt_q) - 1'b1)
      else $error("remaining count did not drop");

endmodule

// File: rtl/dsm_sample_buf.sv
module dsm_sample_buf #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] data
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("dsm_sample_buf: DATA_W must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
      end else if (fill) begin
         full <= 1'b1;
         data <= fill_data;
      end else if (take) begin
         full <= 1'b0;
      end
   end

   a_r10_fill_empty: assert property (@(posedge clk) disable iff (!rst_n)
      fill |-> !full)
      else $error("buffer overwritten");

   a_r10_take_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (take && full && !fill) |=> !full)
      else $error("take did not empty buffer");

   a_r4_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !take) |=> (full && $stable(data)))
      else $error("buffered byte changed");

endmodule

// File: rtl/dsm_reader.sv
module dsm_reader #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned REG_W      = 8,
   parameter int unsigned ADDR_SHIFT = 6,
   parameter int unsigned LEN_SHIFT  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  status,
   output logic              fetch_req,
   output logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_ack,
   input  logic [DATA_W-1:0] fetch_data,
   output logic              buf_full,
   output logic [DATA_W-1:0] buf_data,
   input  logic              buf_take,
   output logic              irq
);
   import dsm_pkg::*;

   generate
      if (REG_W < 8) begin : g_bad_reg
         $error("dsm_reader: REG_W must hold flag and status bits 0..7");
      end
   endgenerate

   dsm_sel_e         sel;
   logic             wr_flags, wr_start, wr_len, wr_ctrl;
   logic             ctrl_on, ctrl_off;
   logic             irq_en_q, loop_q, irq_q;
   logic [REG_W-1:0] start_sel_q, len_sel_q;
   logic             active, last, ack_ok;
   logic             end_loop, end_stop, restart;
   logic             irq_set, irq_clr;

   assign sel      = dsm_sel_e'(wr_sel);
   assign wr_flags = wr_en && (sel == SEL_FLAGS);
   assign wr_start = wr_en && (sel == SEL_START);
   assign wr_len   = wr_en && (sel == SEL_LENGTH);
   assign wr_ctrl  = wr_en && (sel == SEL_CTRL);
   assign ctrl_on  = wr_ctrl &&  wr_data[CTRL_ENABLE];
   assign ctrl_off = wr_ctrl && !wr_data[CTRL_ENABLE];

   assign fetch_req = !buf_full && active;
   assign ack_ok    = fetch_ack && fetch_req;
   assign end_loop  = ack_ok && last &&  loop_q;
   assign end_stop  = ack_ok && last && !loop_q;
   assign restart   = (ctrl_on && !active) || end_loop;
   assign irq_set   = end_stop && irq_en_q;
   assign irq_clr   = wr_ctrl || (wr_flags && !wr_data[FLG_IRQ_EN]);
   assign irq       = irq_q;

   always_comb begin
      status             = '0;
      status[STS_ACTIVE] = active;
      status[STS_IRQ]    = irq_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_en_q    <= 1'b0;
         loop_q      <= 1'b0;
         start_sel_q <= '0;
         len_sel_q   <= '0;
      end else begin
         if (wr_flags) begin
            irq_en_q <= wr_data[FLG_IRQ_EN];
            loop_q   <= wr_data[FLG_LOOP];
         end
         if (wr_start) start_sel_q <= wr_data;
         if (wr_len)   len_sel_q   <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else if (irq_set) begin
         irq_q <= 1'b1;
      end else if (irq_clr) begin
         irq_q <= 1'b0;
      end
   end

   dsm_addr_ctr #(
      .ADDR_W     (ADDR_W),
      .REG_W      (REG_W),
      .ADDR_SHIFT (ADDR_SHIFT)
   ) i_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (restart),
      .step     (ack_ok),
      .base_sel (start_sel_q),
      .addr     (fetch_addr)
   );

   dsm_remain_ctr #(
      .REG_W     (REG_W),
      .LEN_SHIFT (LEN_SHIFT)
   ) i_remain (
      .clk     (clk),
      .rst_n   (rst_n),
      .kill    (ctrl_off),
      .reload  (restart),
      .step    (ack_ok),
      .len_sel (len_sel_q),
      .active  (active),
      .last    (last)
   );

   dsm_sample_buf #(
      .DATA_W (DATA_W)
   ) i_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill      (ack_ok),
      .fill_data (fetch_data),
      .take      (buf_take),
      .full      (buf_full),
      .data      (buf_data)
   );

   a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq)
      else $error("interrupt dropped without clear");

   a_r7_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_ack && fetch_req && last && !loop_q && irq_en_q) |=> irq)
      else $error("interrupt not raised at last byte");

   a_r8_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !irq_set) |=> !irq)
      else $error("interrupt not cleared");

   a_r9_req_off: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_off |=> !fetch_req)
      else $error("request after disable");

   a_r6_loop_active: assert property (@(posedge clk) disable iff (!rst_n)
      (end_loop && !ctrl_off) |=> (status[STS_ACTIVE] && !$rose(irq)))
      else $error("loop did not restart");

   a_r10_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_ack && !fetch_req && !buf_full) |=> !buf_full)
      else $error("stray acknowledge filled buffer");

endmodule

// File: tb/test_dsm_reader.sv
module test_dsm_reader;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 50000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [7:0]  wr_data = 8'd0;
   logic [7:0]  status;
   logic        fetch_req;
   logic [15:0] fetch_addr;
   logic        fetch_ack = 1'b0;
   logic [7:0]  fetch_data = 8'd0;
   logic        buf_full;
   logic [7:0]  buf_data;
   logic        buf_take = 1'b0;
   logic        irq;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   bit auto_ack = 1'b0, auto_take = 1'b0;

   int m_a = 0, m_l = 0, m_ie = 0, m_lp = 0, m_irq = 0;
   int m_addr = 0, m_rem = 0, m_full = 0, m_data = 0, ack_count = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dsm_reader i_dsm_reader (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .status(status), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .fetch_ack(fetch_ack), .fetch_data(fetch_data), .buf_full(buf_full),
      .buf_data(buf_data), .buf_take(buf_take), .irq(irq)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_up();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   endtask

   // behavioural reference model
   always @(posedge clk) begin
      int start, len, nxt;
      bit req, ackv;
      if (!rst_n) begin
         m_a = 0; m_l = 0; m_ie = 0; m_lp = 0; m_irq = 0;
         m_addr = 0; m_rem = 0; m_full = 0; m_data = 0;
      end else begin
         req   = (m_full == 0) && (m_rem != 0);
         ackv  = fetch_ack && req;
         start = 'hC000 + m_a * 64;
         len   = m_l * 16 + 1;
         nxt   = (m_addr == 'hFFFF) ? 'h8000 : m_addr + 1;
         if (ackv) begin
            m_full = 1; m_data = fetch_data; ack_count++;
            if (m_rem == 1) begin
               if (m_lp != 0) begin m_addr = start; m_rem = len; end
               else begin m_rem = 0; m_addr = nxt; if (m_ie != 0) m_irq = 1; end
            end else begin
               m_addr = nxt; m_rem--;
            end
         end else if (buf_take && m_full != 0) begin
            m_full = 0;
         end
         if (wr_en) begin
            case (wr_sel)
               2'd0: begin m_ie = wr_data[7]; m_lp = wr_data[6]; if (!wr_data[7]) m_irq = 0; end
               2'd1: m_a = wr_data;
               2'd2: m_l = wr_data;
               default: begin
                  m_irq = 0;
                  if (wr_data[4]) begin
                     if (m_rem == 0) begin m_addr = start; m_rem = len; end
                  end else m_rem = 0;
               end
            endcase
         end
      end
   end

   // memory and output-unit responders
   always @(posedge clk) begin
      #2;
      if (auto_ack) begin
         fetch_ack  = fetch_req && !wr_en;
         fetch_data = fetch_addr[7:0] ^ fetch_addr[15:8] ^ 8'h3C;
      end
      buf_take = auto_take && buf_full;
   end

   // per-cycle comparison
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R3 fetch_req", fetch_req, (m_full == 0 && m_rem != 0));
         chk("R4 fetch_addr", fetch_addr, m_addr);
         chk("R10 buf_full", buf_full, m_full);
         if (m_full != 0) chk("R4 buf_data", buf_data, m_data);
         chk("R7 irq", irq, m_irq);
         chk("R11 status", status, (m_irq << 7) | ((m_rem != 0) << 4));
      end
   end

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic wait_acks(input int n);
      int target;
      target = ack_count + n;
      while (ack_count < target) @(negedge clk);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         finish_up();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R1 status", status, 0);
      chk("R1 fetch_req", fetch_req, 0);
      chk("R1 irq", irq, 0);
      chk("R1 buf_full", buf_full, 0);

      auto_ack = 1'b1; auto_take = 1'b1;

      // plain 17-byte sample, no interrupt
      wr(2'd1, 8'h10);
      wr(2'd2, 8'h01);
      wr(2'd0, 8'h00);
      wr(2'd3, 8'h10);
      @(negedge clk);
      chk("R2 start addr", fetch_addr, 'hC400);
      chk("R2 request", fetch_req, 1);
      chk("R11 active bit", status, 'h10);
      while (status[4]) @(negedge clk);
      chk("R7 no irq when disabled", irq, 0);

      // re-enable while running and disable
      wr(2'd3, 8'h10);
      wait_acks(3);
      wr(2'd3, 8'h10);
      @(negedge clk);
      chk("R9 no restart while active", fetch_addr, 'hC403);
      chk("R9 still active", status, 'h10);
      wr(2'd3, 8'h00);
      @(negedge clk);
      chk("R9 disable stops request", fetch_req, 0);
      chk("R9 disable clears active", status, 0);

      // wrap past the top of the space
      wr(2'd1, 8'hFF);
      wr(2'd2, 8'h04);
      wr(2'd3, 8'h10);
      wait_acks(64);
      chk("R5 wrap to 8000", fetch_addr, 'h8000);
      while (status[4]) @(negedge clk);

      // interrupt on last byte
      wr(2'd1, 8'h20);
      wr(2'd2, 8'h00);
      wr(2'd0, 8'h80);
      wr(2'd3, 8'h10);
      while (!irq) @(negedge clk);
      repeat (5) @(negedge clk);
      chk("R7 irq held", irq, 1);
      chk("R11 irq bit", status, 'h80);
      wr(2'd0, 8'h80);
      @(negedge clk);
      chk("R8 flags bit7 set keeps irq", irq, 1);
      wr(2'd0, 8'h00);
      @(negedge clk);
      chk("R8 flags clear", irq, 0);
      wr(2'd0, 8'h80);
      wr(2'd3, 8'h10);
      while (!irq) @(negedge clk);
      wr(2'd3, 8'h00);
      @(negedge clk);
      chk("R8 control write clears", irq, 0);

      // looping single-byte sample
      wr(2'd0, 8'h40);
      wr(2'd1, 8'h02);
      wr(2'd2, 8'h00);
      wr(2'd3, 8'h10);
      wait_acks(3);
      chk("R6 loop address", fetch_addr, 'hC080);
      chk("R6 loop active", status, 'h10);
      chk("R6 no irq on loop", irq, 0);
      wr(2'd3, 8'h00);

      // stray acknowledge with nothing requested
      auto_ack = 1'b0;
      fetch_ack = 1'b0;
      while (buf_full) @(negedge clk);
      @(posedge clk); #1;
      fetch_ack = 1'b1; fetch_data = 8'hA5;
      @(posedge clk); #1;
      fetch_ack = 1'b0;
      @(negedge clk);
      chk("R10 stray ack ignored", buf_full, 0);
      repeat (4) @(negedge clk);

      finish_up();
   end
endmodule